// File: doc/BRIEF.md
# User Interrupt Posting Engine

This block carries out a single user-level interrupt send. A requester supplies an index into an in-memory routing table. The block checks that sending is enabled and that the index is in range. It then fetches the 16-byte table entry and validates it. The entry names a user vector and the address of a 16-byte posting descriptor. The block reads that descriptor, sets the pending bit for the vector in the descriptor's request bitmap, and writes both descriptor words back. If neither the outstanding flag nor the suppress flag was set, it also marks the notification as outstanding.

When the descriptor update marked a notification as outstanding, the block emits a notification request that carries a target identifier and an interrupt vector. The target is taken as a full 32-bit identifier in extended mode. In compact mode it is an 8-bit identifier.

All memory traffic goes through one 64-bit request/grant port with a separate read-data valid. A lock output spans the descriptor read-modify-write so that the fabric can keep it indivisible. Every request ends with a one-cycle done pulse. The pulse carries a fault flag and a fault kind.

Top module: `uipi_post_engine`

## Requirements
- R1: When a request starts with send_en_i low, done_o pulses on the next cycle with fault_o high and fault_kind_o = 1 (undefined operation), and no memory request is issued.
- R2: When index_i is greater than tbl_size_i, the request ends with fault_kind_o = 2 (general protection) and no memory request; an index equal to tbl_size_i is accepted.
- R3: The entry address is tbl_base_i with bits 3:0 cleared plus 16 times index_i; the block reads the entry's low word at that address, then its descriptor-address word at +8.
- R4: The entry faults with kind 2 and no descriptor access when its bit 0 is clear or any bit under mask 0xFFFF_FFFF_FFFF_00FE is set.
- R5: The entry faults with kind 2 when its vector (bits 15:8) is 64 or more, or when the descriptor address word has any of bits 5:0 set.
- R6: When the descriptor low word has any bit under mask 0x0000_0000_FF00_FFFC set, the request faults with kind 2 after reading only that word, and nothing is written.
- R7: On success the descriptor low word is written back at the descriptor address and then the high word at +8; the high word gains bit [vector]; the low word gains bit 0 only when its bits 1:0 were both zero, and is otherwise unchanged.
- R8: ntf_valid_o pulses together with a fault-free done_o exactly when descriptor bits 1:0 were both zero; ntf_vec_o is descriptor bits 23:16; ntf_dest_o is descriptor bits 63:32 when x2apic_i is high, else bits 47:40 zero-extended.
- R9: lock_o is high throughout the descriptor accesses, from the first descriptor read until the grant of the second descriptor write; entry reads are issued with lock_o low, and lock_o is low when done_o pulses.
- R10: A raised mem_req_o keeps its address, write enable and write data until mem_gnt_i; read data is taken only on mem_rvalid_i, with at most one read outstanding.
- R11: done_o is a single-cycle pulse; fault_o is high with it exactly when fault_kind_o is nonzero (0 means no fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a send (sampled when idle) |
| index_i | input | IDX_W | Table index |
| tbl_base_i | input | ADDR_W | Table base address |
| tbl_size_i | input | IDX_W | Largest valid index |
| send_en_i | input | 1 | Sending enabled |
| x2apic_i | input | 1 | Extended (32-bit) target identifier mode |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| lock_o | output | 1 | Descriptor read-modify-write in progress |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| fault_o | output | 1 | Request ended in a fault |
| fault_kind_o | output | 2 | 0 none, 1 undefined operation, 2 general protection |
| ntf_valid_o | output | 1 | Notification request |
| ntf_vec_o | output | 8 | Notification vector |
| ntf_dest_o | output | 32 | Notification target identifier |

## Verification
The bench builds the engine with a 32-bit address and a 6-bit index. The narrow address truncates the descriptor-address word, so the bench covers the block below its default width. The small index lets it reach the top of the table. It sets the table size to 10, so index 10 is the last valid index and index 11 is the first rejected one. The bench also places the table at a base with low bits set. Grant delays and read latencies come from a pseudo-random sequence, so each access kind is exercised both when it is granted at once and when it is held off.

// File: rtl/uipi_pkg.sv
`timescale 1ns/1ps
package uipi_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_E0,
    ST_RD_E1,
    ST_CHK_E,
    ST_RD_D0,
    ST_CHK_D,
    ST_RD_D1,
    ST_WR_D0,
    ST_WR_D1
  } state_e;

  localparam logic [63:0] ENTRY_RSVD_MASK = 64'hFFFF_FFFF_FFFF_00FE;
  localparam logic [63:0] DESC_RSVD_MASK  = 64'h0000_0000_FF00_FFFC;
  localparam int unsigned NUM_UVEC        = 64;
  localparam int unsigned UVEC_W          = $clog2(NUM_UVEC);
endpackage

// File: rtl/uipi_entry_check.sv
`timescale 1ns/1ps
module uipi_entry_check
  import uipi_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [63:0]       entry_lo_i,
  input  logic [63:0]       entry_hi_i,
  output logic              fault_o,
  output logic [UVEC_W-1:0] uvec_o,
  output logic [ADDR_W-1:0] desc_addr_o
);
  localparam logic [7:0] VEC_LIM = 8'(NUM_UVEC);

  logic [7:0] vec_raw;
  logic       not_valid, rsvd_set, vec_oob, misaligned;

  always_comb begin
    vec_raw    = entry_lo_i[15:8];
    not_valid  = ~entry_lo_i[0];
    rsvd_set   = |(entry_lo_i & ENTRY_RSVD_MASK);
    vec_oob    = vec_raw >= VEC_LIM;
    misaligned = |entry_hi_i[5:0];
    fault_o    = not_valid | rsvd_set | vec_oob | misaligned;
    uvec_o     = vec_raw[UVEC_W-1:0];
  end

  generate
    if (ADDR_W >= 64) begin : g_full
      assign desc_addr_o = ADDR_W'(entry_hi_i);
    end else begin : g_trunc
      assign desc_addr_o = entry_hi_i[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/uipi_desc_update.sv
`timescale 1ns/1ps
module uipi_desc_update
  import uipi_pkg::*;
(
  input  logic [63:0]       d0_i,
  input  logic [63:0]       d1_i,
  input  logic [UVEC_W-1:0] uvec_i,
  input  logic              x2apic_i,
  output logic              rsvd_fault_o,
  output logic [63:0]       d0_new_o,
  output logic [63:0]       d1_new_o,
  output logic              notify_o,
  output logic [7:0]        ntf_vec_o,
  output logic [31:0]       ntf_dest_o
);
  always_comb begin
    rsvd_fault_o = |(d0_i & DESC_RSVD_MASK);
    notify_o     = (d0_i[1:0] == 2'b00);
    d1_new_o     = d1_i | (64'd1 << uvec_i);
    d0_new_o     = notify_o ? (d0_i | 64'd1) : d0_i;
    ntf_vec_o    = d0_i[23:16];
    ntf_dest_o   = x2apic_i ? d0_i[63:32] : {24'd0, d0_i[47:40]};
  end
endmodule

// File: rtl/uipi_ctrl.sv
`timescale 1ns/1ps
module uipi_ctrl
  import uipi_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [IDX_W-1:0]  tbl_size_i,
  input  logic              send_en_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic [63:0]       entry_lo_o,
  output logic [63:0]       entry_hi_o,
  input  logic              ent_fault_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic [63:0]       d0_o,
  output logic [63:0]       d1_o,
  input  logic              dsc_fault_i,
  input  logic [63:0]       d0_new_i,
  input  logic [63:0]       d1_new_i,
  input  logic              notify_i,
  input  logic [7:0]        ntf_vec_i,
  input  logic [31:0]       ntf_dest_i,
  output logic              lock_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_kind_o,
  output logic              ntf_valid_o,
  output logic [7:0]        ntf_vec_o,
  output logic [31:0]       ntf_dest_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(15);
  localparam logic [ADDR_W-1:0] WORD_OFS  = ADDR_W'(8);

  state_e            state_q;
  logic              rd_wait_q;
  logic [ADDR_W-1:0] ent_q, desc_q, ent_addr;
  logic [63:0]       lo_q, hi_q, d0_q, d1_q;
  logic              done_q, fault_q, ntf_q;
  fault_e            kind_q;
  logic [7:0]        vec_q;
  logic [31:0]       dest_q;
  logic              is_rd, is_wr, rd_back;

  assign ent_addr = (tbl_base_i & LINE_MASK) + (ADDR_W'(index_i) << 4);

  always_comb begin
    is_rd = (state_q == ST_RD_E0) || (state_q == ST_RD_E1) ||
            (state_q == ST_RD_D0) || (state_q == ST_RD_D1);
    is_wr = (state_q == ST_WR_D0) || (state_q == ST_WR_D1);
    rd_back = rd_wait_q && mem_rvalid_i;
    mem_req_o   = (is_rd && !rd_wait_q) || is_wr;
    mem_we_o    = is_wr;
    mem_wdata_o = (state_q == ST_WR_D1) ? d1_new_i : d0_new_i;
    unique case (state_q)
      ST_RD_E0: mem_addr_o = ent_q;
      ST_RD_E1: mem_addr_o = ent_q + WORD_OFS;
      ST_RD_D1, ST_WR_D1: mem_addr_o = desc_q + WORD_OFS;
      ST_RD_D0, ST_WR_D0: mem_addr_o = desc_q;
      default:  mem_addr_o = '0;
    endcase
    lock_o = (state_q == ST_RD_D0) || (state_q == ST_CHK_D) ||
             (state_q == ST_RD_D1) || is_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_wait_q <= 1'b0;
      ent_q     <= '0;
      desc_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      d0_q      <= '0;
      d1_q      <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      kind_q    <= FLT_NONE;
      ntf_q     <= 1'b0;
      vec_q     <= '0;
      dest_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      kind_q  <= FLT_NONE;
      ntf_q   <= 1'b0;
      if (is_rd && !rd_wait_q && mem_gnt_i) rd_wait_q <= 1'b1;
      if (rd_back) rd_wait_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (!send_en_i) begin
            done_q <= 1'b1; fault_q <= 1'b1; kind_q <= FLT_UD;
          end else if (index_i > tbl_size_i) begin
            done_q <= 1'b1; fault_q <= 1'b1; kind_q <= FLT_GP;
          end else begin
            ent_q   <= ent_addr;
            state_q <= ST_RD_E0;
          end
        end
        ST_RD_E0: if (rd_back) begin
          lo_q    <= mem_rdata_i;
          state_q <= ST_RD_E1;
        end
        ST_RD_E1: if (rd_back) begin
          hi_q    <= mem_rdata_i;
          state_q <= ST_CHK_E;
        end
        ST_CHK_E: begin
          if (ent_fault_i) begin
            done_q <= 1'b1; fault_q <= 1'b1; kind_q <= FLT_GP;
            state_q <= ST_IDLE;
          end else begin
            desc_q  <= desc_addr_i;
            state_q <= ST_RD_D0;
          end
        end
        ST_RD_D0: if (rd_back) begin
          d0_q    <= mem_rdata_i;
          state_q <= ST_CHK_D;
        end
        ST_CHK_D: begin
          if (dsc_fault_i) begin
            done_q <= 1'b1; fault_q <= 1'b1; kind_q <= FLT_GP;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RD_D1;
          end
        end
        ST_RD_D1: if (rd_back) begin
          d1_q    <= mem_rdata_i;
          state_q <= ST_WR_D0;
        end
        ST_WR_D0: if (mem_gnt_i) state_q <= ST_WR_D1;
        ST_WR_D1: if (mem_gnt_i) begin
          done_q  <= 1'b1;
          ntf_q   <= notify_i;
          vec_q   <= ntf_vec_i;
          dest_q  <= ntf_dest_i;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign entry_lo_o   = lo_q;
  assign entry_hi_o   = hi_q;
  assign d0_o         = d0_q;
  assign d1_o         = d1_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_kind_o = kind_q;
  assign ntf_valid_o  = ntf_q;
  assign ntf_vec_o    = vec_q;
  assign ntf_dest_o   = dest_q;
endmodule

// File: rtl/uipi_post_engine.sv
`timescale 1ns/1ps
module uipi_post_engine
  import uipi_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [IDX_W-1:0]  tbl_size_i,
  input  logic              send_en_i,
  input  logic              x2apic_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              lock_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_kind_o,
  output logic              ntf_valid_o,
  output logic [7:0]        ntf_vec_o,
  output logic [31:0]       ntf_dest_o
);
  logic [63:0]       lo, hi, d0, d1, d0_new, d1_new;
  logic              ent_fault, dsc_fault, notify;
  logic [UVEC_W-1:0] uvec;
  logic [ADDR_W-1:0] desc_addr;
  logic [7:0]        nvec;
  logic [31:0]       ndest;

  uipi_entry_check #(.ADDR_W(ADDR_W)) i_entry_check (
    .entry_lo_i  (lo),
    .entry_hi_i  (hi),
    .fault_o     (ent_fault),
    .uvec_o      (uvec),
    .desc_addr_o (desc_addr)
  );

  uipi_desc_update i_desc_update (
    .d0_i         (d0),
    .d1_i         (d1),
    .uvec_i       (uvec),
    .x2apic_i     (x2apic_i),
    .rsvd_fault_o (dsc_fault),
    .d0_new_o     (d0_new),
    .d1_new_o     (d1_new),
    .notify_o     (notify),
    .ntf_vec_o    (nvec),
    .ntf_dest_o   (ndest)
  );

  uipi_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .index_i      (index_i),
    .tbl_base_i   (tbl_base_i),
    .tbl_size_i   (tbl_size_i),
    .send_en_i    (send_en_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .entry_lo_o   (lo),
    .entry_hi_o   (hi),
    .ent_fault_i  (ent_fault),
    .desc_addr_i  (desc_addr),
    .d0_o         (d0),
    .d1_o         (d1),
    .dsc_fault_i  (dsc_fault),
    .d0_new_i     (d0_new),
    .d1_new_i     (d1_new),
    .notify_i     (notify),
    .ntf_vec_i    (nvec),
    .ntf_dest_i   (ndest),
    .lock_o       (lock_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_kind_o (fault_kind_o),
    .ntf_valid_o  (ntf_valid_o),
    .ntf_vec_o    (ntf_vec_o),
    .ntf_dest_o   (ntf_dest_o)
  );
endmodule

// File: rtl/uipi_post_chk.sv
`timescale 1ns/1ps
module uipi_post_chk #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [63:0]       mem_wdata_o,
  input logic              lock_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [1:0]        fault_kind_o,
  input logic              ntf_valid_o
);
  assert_write_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> lock_o);

  assert_unlocked_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lock_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_ntf_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> (done_o && !fault_o));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fault_kind_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o == (fault_kind_o != 2'd0)));

  assert_fault_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !fault_o);
endmodule

bind uipi_post_engine uipi_post_chk #(.ADDR_W(ADDR_W)) i_post_chk (.*);

// File: tb/test_uipi_post_engine.sv
`timescale 1ns/1ps
module test_uipi_post_engine;
  localparam int unsigned AW = 32;
  localparam int unsigned IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] index = '0, tsize = '0;
  logic [AW-1:0] base = '0;
  logic          send_en = 1'b0, x2 = 1'b0;
  logic          mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata = '0;
  logic          lock, done, fault, ntf_valid;
  logic [1:0]    fkind;
  logic [7:0]    ntf_vec;
  logic [31:0]   ntf_dest;

  always #4 clk = ~clk;

  uipi_post_engine #(.ADDR_W(AW), .IDX_W(IW)) i_uipi_post_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .index_i(index),
    .tbl_base_i(base), .tbl_size_i(tsize), .send_en_i(send_en), .x2apic_i(x2),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .lock_o(lock), .done_o(done), .fault_o(fault),
    .fault_kind_o(fkind), .ntf_valid_o(ntf_valid), .ntf_vec_o(ntf_vec),
    .ntf_dest_o(ntf_dest)
  );

  int n_tests = 0, n_fail = 0;
  logic [63:0]   mem [logic [AW-1:0]];
  bit            exp_we [$];
  bit            exp_lk [$];
  logic [AW-1:0] exp_addr [$];
  logic [63:0]   exp_wd [$];
  string         exp_tag [$];
  bit            txn_active = 1'b0;
  logic [7:0]    lfsr = 8'hA5;
  int            rd_cnt = 0;
  logic [63:0]   rd_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic push(input bit we, input logic [AW-1:0] a, input logic [63:0] wd,
                      input bit lk, input string tag);
    exp_we.push_back(we); exp_addr.push_back(a); exp_wd.push_back(wd);
    exp_lk.push_back(lk); exp_tag.push_back(tag);
  endtask

  // memory responder and per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_gnt = 1'b0;
      mem_rvalid = 1'b0;
      if (!txn_active && rst_n)
        chk(!mem_req, "R10", "request while idle", 64'(mem_req), 64'd0);
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = rd_data;
        end
      end else if (mem_req && lfsr[1:0] != 2'b00) begin
        mem_gnt = 1'b1;
        if (exp_we.size() == 0) begin
          chk(1'b0, "R3", "unexpected access", 64'(mem_addr), 64'd0);
        end else begin
          automatic bit            we  = exp_we.pop_front();
          automatic bit            lk  = exp_lk.pop_front();
          automatic logic [AW-1:0] a   = exp_addr.pop_front();
          automatic logic [63:0]   wd  = exp_wd.pop_front();
          automatic string         tg  = exp_tag.pop_front();
          chk(mem_we == we, tg, "access kind", 64'(mem_we), 64'(we));
          chk(mem_addr == a, tg, "address", 64'(mem_addr), 64'(a));
          chk(lock == lk, "R9", "lock at access", 64'(lock), 64'(lk));
          if (we) chk(mem_wdata == wd, "R7", "write data", mem_wdata, wd);
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else begin
          rd_data = rd(mem_addr);
          rd_cnt = lfsr[2] ? 2 : 1;
        end
      end
    end
  end

  task automatic run(input string tag, input bit en, input bit x2m,
                     input logic [AW-1:0] b, input logic [IW-1:0] sz,
                     input logic [IW-1:0] ix);
    logic [AW-1:0] ea, da;
    logic [63:0]   lo, hi, d0, d1;
    logic [1:0]    ekind;
    bit            entf;
    logic [7:0]    evec;
    logic [31:0]   edest;
    bit            got;
    ekind = 2'd0; entf = 1'b0; evec = '0; edest = '0;
    if (!en) ekind = 2'd1;
    else if (ix > sz) ekind = 2'd2;
    else begin
      ea = (b & ~32'hF) + 32'(ix) * 16;
      push(1'b0, ea, 64'd0, 1'b0, "R3");
      push(1'b0, ea + 8, 64'd0, 1'b0, "R3");
      lo = rd(ea); hi = rd(ea + 8);
      if (!lo[0] || (lo & 64'hFFFF_FFFF_FFFF_00FE) != 0 || lo[15:8] >= 64 || hi[5:0] != 0)
        ekind = 2'd2;
      else begin
        da = hi[AW-1:0];
        push(1'b0, da, 64'd0, 1'b1, "R6");
        d0 = rd(da);
        if ((d0 & 64'h0000_0000_FF00_FFFC) != 0) ekind = 2'd2;
        else begin
          push(1'b0, da + 8, 64'd0, 1'b1, "R7");
          d1 = rd(da + 8);
          entf = (d0[1:0] == 2'b00);
          push(1'b1, da, entf ? (d0 | 64'd1) : d0, 1'b1, "R7");
          push(1'b1, da + 8, d1 | (64'd1 << lo[13:8]), 1'b1, "R7");
          evec = d0[23:16];
          edest = x2m ? d0[63:32] : {24'd0, d0[47:40]};
        end
      end
    end
    @(negedge clk);
    txn_active = 1'b1;
    send_en = en; x2 = x2m; base = b; tsize = sz; index = ix; start = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin got = 1'b1; break; end
    end
    chk(got, tag, "done seen", 64'(got), 64'd1);
    if (got) begin
      chk(fkind == ekind, tag, "fault kind", 64'(fkind), 64'(ekind));
      chk(fault == (ekind != 0), "R11", "fault flag", 64'(fault), 64'(ekind != 0));
      chk(!lock, "R9", "lock at done", 64'(lock), 64'd0);
      chk(ntf_valid == entf, "R8", "notify valid", 64'(ntf_valid), 64'(entf));
      if (entf) begin
        chk(ntf_vec == evec, "R8", "notify vector", 64'(ntf_vec), 64'(evec));
        chk(ntf_dest == edest, "R8", "notify target", 64'(ntf_dest), 64'(edest));
      end
    end
    chk(exp_we.size() == 0, tag, "accesses left", 64'(exp_we.size()), 64'd0);
    exp_we.delete(); exp_lk.delete(); exp_addr.delete(); exp_wd.delete(); exp_tag.delete();
    @(negedge clk);
    chk(!done, "R11", "done pulse width", 64'(done), 64'd0);
    txn_active = 1'b0;
  endtask

  localparam logic [63:0] D0A = 64'h1234_5678_003A_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req && !lock && !ntf_valid && !fault, "R11", "reset state",
        {59'd0, done, mem_req, lock, ntf_valid, fault}, 64'd0);
    // table at 0x1000, entries 16 bytes each
    mem[32'h1030] = 64'h0501;              mem[32'h1038] = 64'h2000;
    mem[32'h2000] = D0A;                   mem[32'h2008] = 64'h1;
    mem[32'h10A0] = 64'h3F01;              mem[32'h10A8] = 64'h2040;
    mem[32'h2040] = 64'hCAFE_0001_0091_0000; mem[32'h2048] = 64'h0;
    mem[32'h1040] = 64'h0001;              mem[32'h1048] = 64'h2080;
    mem[32'h2080] = 64'h0000_0000_0022_0002; mem[32'h2088] = 64'h8;
    mem[32'h1050] = 64'h0500;              mem[32'h1058] = 64'h2000;
    mem[32'h1060] = 64'h0509;              mem[32'h1068] = 64'h2000;
    mem[32'h1070] = 64'h4001;              mem[32'h1078] = 64'h2000;
    mem[32'h1080] = 64'h0501;              mem[32'h1088] = 64'h2010;
    mem[32'h1090] = 64'h0501;              mem[32'h1098] = 64'h20C0;
    mem[32'h20C0] = 64'h0100_0000;
    mem[32'h1000] = 64'h0100_0000_0501;    mem[32'h1008] = 64'h2000;
    mem[32'h1010] = 64'h0501;              mem[32'h1018] = 64'h2100;
    mem[32'h2100] = 64'h0004;

    run("R1", 1'b0, 1'b0, 32'h1000, 6'd10, 6'd3);  // disabled
    run("R2", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd11); // index above size
    run("R3", 1'b1, 1'b0, 32'h1007, 6'd10, 6'd3);  // base low bits ignored, notify compact
    run("R2", 1'b1, 1'b1, 32'h1000, 6'd10, 6'd10); // index equal to size, vector 63, x2 mode
    run("R7", 1'b1, 1'b1, 32'h1000, 6'd10, 6'd10); // outstanding already set
    run("R7", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd4);  // suppress set, vector 0
    run("R4", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd5);  // not valid
    run("R4", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd6);  // reserved bit 3
    run("R4", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd0);  // reserved bit 40
    run("R5", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd7);  // vector 64
    run("R5", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd8);  // descriptor misaligned
    run("R6", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd9);  // descriptor reserved bit 24
    run("R6", 1'b1, 1'b0, 32'h1000, 6'd10, 6'd1);  // descriptor reserved bit 2
    mem[32'h2000] = D0A;
    run("R8", 1'b1, 1'b1, 32'h100F, 6'd10, 6'd3);  // full-width target
    chk(mem[32'h2008] == 64'h21, "R7", "bitmap after sends", mem[32'h2008], 64'h21);
    chk(mem[32'h20C0] == 64'h0100_0000, "R6", "faulted descriptor untouched",
        mem[32'h20C0], 64'h0100_0000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule